// File: doc/BRIEF.md
# FP64 Compare-and-Set Execution Unit

This unit executes one compare-and-set instruction per accepted transfer. It takes a 64-bit instruction word, two IEEE-754 double-precision operands that have already been fetched, and an 8-entry predicate file. It optionally applies absolute value and negation to each operand, then compares them under one of sixteen ordered or unordered conditions. The outcome is merged with one predicate, which may be inverted, through a boolean operator. The unit then produces a 32-bit result: an all-ones mask or single-precision 1.0 on pass, and zero on fail. When the instruction asks for it, the unit also updates four persistent condition flags.

The input and the output are each a valid/ready stream, with one register stage between them. An instruction is accepted on a clock edge where `in_valid` and `in_ready` are both high. The result appears on the next cycle with `out_valid` high. It stays stable until a cycle with `out_ready` high takes it. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so full throughput is possible under continuous ready. The flags change on the accepting edge. They are not part of the stream.

Top module: `dcs_unit`

## Requirements
- R1: `res_dest` carries instruction bits [7:0] of the accepted instruction, registered together with its result.
- R2: Operand modifiers are abs A = bit 54, negate A = bit 43, abs B = bit 44 and negate B = bit 53. Absolute value clears the sign bit and negation inverts it. When both are set, abs is applied first.
- R3: Bits [51:48] select the condition: 0 never, 1 LT, 2 EQ, 3 LE, 4 GT, 5 NE, 6 GE, 7 ordered, 8 unordered, 9 LTU, 10 EQU, 11 LEU, 12 GTU, 13 NEU, 14 GEU, 15 always. Codes 1 to 6 pass only on non-NaN operands that satisfy the relation.
- R4: If either modified operand is a NaN (exponent all ones, fraction non-zero), codes 1 to 7 fail and codes 8 to 14 pass.
- R5: +0 and -0 compare as equal.
- R6: Bits [41:39] index the predicate file entry that is merged. Bit 42 inverts that entry before the merge.
- R7: Bits [46:45] choose the merge operator: 0 AND, 1 OR, 2 XOR, 3 AND.
- R8: A merged pass gives 0xFFFFFFFF when bit 52 is clear and 0x3F800000 when bit 52 is set. A merged fail gives 0x00000000.
- R9: On an accepted instruction with bit 47 set, the zero flag is set exactly when the result is zero. The sign flag is cleared when bit 52 is set, and otherwise equals the inverse of the zero flag. Carry and overflow are cleared.
- R10: On an accepted instruction with bit 47 clear, all four flags keep their values.
- R11: `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `res_data` and `res_dest` hold. After reset, `out_valid` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands present |
| in_ready | output | 1 | Unit can accept this cycle |
| insn | input | 64 | Instruction word |
| src_a | input | 64 | Operand A, FP64 bits |
| src_b | input | 64 | Operand B, FP64 bits |
| pred_file | input | 8 | Predicate file, one bit per entry |
| out_valid | output | 1 | Result register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| res_data | output | 32 | Result word |
| res_dest | output | 8 | Destination register index |
| flag_zero | output | 1 | Zero flag |
| flag_sign | output | 1 | Sign flag |
| flag_carry | output | 1 | Carry flag |
| flag_ovf | output | 1 | Overflow flag |

## Verification
Two things can happen on the same edge: a new instruction is accepted and the previous result is drained. When this happens, the result register and the flags must take the new values while the old result counts as consumed. The bench provokes this by streaming instructions back to back while `out_ready` toggles at random. This creates drain-and-refill edges, stalls with a full register, and idle cycles. A behavioural model compares the ready/valid pins, the result word, the destination and the four flags on every cycle. The operands come from a pool of signed zeros, infinities, NaNs, denormals and ordinary values, so that the R4 and R5 cases meet every condition code.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int unsigned INSN_W = 64;
  localparam int unsigned RES_W  = 32;
  localparam int unsigned PRED_N = 8;
  localparam int unsigned PSEL_W = $clog2(PRED_N);

  typedef enum logic [1:0] {
    BOP_AND  = 2'd0,
    BOP_OR   = 2'd1,
    BOP_XOR  = 2'd2,
    BOP_AND2 = 2'd3
  } bop_e;

  typedef enum logic [3:0] {
    CND_NEVER = 4'd0,  CND_LT   = 4'd1,  CND_EQ   = 4'd2,  CND_LE  = 4'd3,
    CND_GT    = 4'd4,  CND_NE   = 4'd5,  CND_GE   = 4'd6,  CND_ORD = 4'd7,
    CND_UNORD = 4'd8,  CND_LTU  = 4'd9,  CND_EQU  = 4'd10, CND_LEU = 4'd11,
    CND_GTU   = 4'd12, CND_NEU  = 4'd13, CND_GEU  = 4'd14, CND_ALWAYS = 4'd15
  } cnd_e;

  typedef struct packed {
    logic [7:0]        dest;
    logic [PSEL_W-1:0] psel;
    logic              pinv;
    logic              a_abs;
    logic              a_neg;
    logic              b_abs;
    logic              b_neg;
    bop_e              bop;
    logic              upd_flags;
    cnd_e              cnd;
    logic              float_one;
  } fields_t;

  function automatic logic [63:0] fp_modify(input logic [63:0] x,
                                            input logic do_abs,
                                            input logic do_neg);
    logic [63:0] t;
    t = x;
    if (do_abs) t[63] = 1'b0;
    if (do_neg) t[63] = ~t[63];
    return t;
  endfunction
endpackage

// File: rtl/dcs_decode.sv
module dcs_decode
  import dcs_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output fields_t           f
);
  // Bits not used by this unit (source index, opcode space).
  logic unused_insn_bits;
  assign unused_insn_bits = ^{insn[63:55], insn[38:8]};

  always_comb begin
    f.dest      = insn[7:0];
    f.psel      = insn[39 +: PSEL_W];
    f.pinv      = insn[42];
    f.a_neg     = insn[43];
    f.b_abs     = insn[44];
    f.bop       = bop_e'(insn[46:45]);
    f.upd_flags = insn[47];
    f.cnd       = cnd_e'(insn[51:48]);
    f.float_one = insn[52];
    f.b_neg     = insn[53];
    f.a_abs     = insn[54];
  end
endmodule

// File: rtl/dcs_fp64_cmp.sv
module dcs_fp64_cmp
  import dcs_pkg::*;
#(
  parameter int unsigned EXP_W  = 11,
  parameter int unsigned FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] a,
  input  logic [EXP_W+FRAC_W:0] b,
  input  cnd_e                  cnd,
  output logic                  pass
);
  localparam int unsigned W = 1 + EXP_W + FRAC_W;

  logic         a_nan, b_nan, unord, both_zero;
  logic [W-1:0] ka, kb;
  logic         lt, eq, gt;

  // Monotonic key: positives get sign set, negatives are inverted.
  function automatic logic [W-1:0] order_key(input logic [W-1:0] x);
    return x[W-1] ? ~x : (x ^ {1'b1, {(W-1){1'b0}}});
  endfunction

  always_comb begin
    a_nan     = (&a[W-2 -: EXP_W]) && (|a[FRAC_W-1:0]);
    b_nan     = (&b[W-2 -: EXP_W]) && (|b[FRAC_W-1:0]);
    unord     = a_nan | b_nan;
    both_zero = ~|{a[W-2:0], b[W-2:0]};
    ka        = order_key(a);
    kb        = order_key(b);
    eq        = !unord && (both_zero || (a == b));
    lt        = !unord && !eq && (ka < kb);
    gt        = !unord && !eq && !lt;
  end

  always_comb begin
    unique case (cnd)
      CND_NEVER:  pass = 1'b0;
      CND_LT:     pass = lt;
      CND_EQ:     pass = eq;
      CND_LE:     pass = lt | eq;
      CND_GT:     pass = gt;
      CND_NE:     pass = lt | gt;
      CND_GE:     pass = gt | eq;
      CND_ORD:    pass = !unord;
      CND_UNORD:  pass = unord;
      CND_LTU:    pass = unord | lt;
      CND_EQU:    pass = unord | eq;
      CND_LEU:    pass = unord | lt | eq;
      CND_GTU:    pass = unord | gt;
      CND_NEU:    pass = unord | lt | gt;
      CND_GEU:    pass = unord | gt | eq;
      default:    pass = 1'b1;
    endcase
  end

  // Exactly one relation holds for ordered operands.
  always_comb begin
    if (!unord) assert ($countones({lt, eq, gt}) == 1); // R3
  end
endmodule

// File: rtl/dcs_merge.sv
module dcs_merge
  import dcs_pkg::*;
(
  input  logic                  cmp_pass,
  input  logic [PRED_N-1:0]     preds,
  input  logic [PSEL_W-1:0]     psel,
  input  logic                  pinv,
  input  bop_e                  bop,
  input  logic                  float_one,
  output logic [RES_W-1:0]      result
);
  localparam logic [RES_W-1:0] MASK_ONES = '1;
  localparam logic [RES_W-1:0] FLT_ONE   = RES_W'(32'h3F80_0000);

  logic p, hit;

  always_comb begin
    p = preds[psel] ^ pinv;
    unique case (bop)
      BOP_OR:  hit = cmp_pass | p;
      BOP_XOR: hit = cmp_pass ^ p;
      default: hit = cmp_pass & p;
    endcase
    result = hit ? (float_one ? FLT_ONE : MASK_ONES) : '0;
  end
endmodule

// File: rtl/dcs_unit.sv
module dcs_unit
  import dcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INSN_W-1:0] insn,
  input  logic [63:0]       src_a,
  input  logic [63:0]       src_b,
  input  logic [PRED_N-1:0] pred_file,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [RES_W-1:0]  res_data,
  output logic [7:0]        res_dest,
  output logic              flag_zero,
  output logic              flag_sign,
  output logic              flag_carry,
  output logic              flag_ovf
);
  fields_t          f;
  logic [63:0]      op_a, op_b;
  logic             cmp_pass;
  logic [RES_W-1:0] result;
  logic             in_fire;
  logic [3:0]       flags_q;   // {z, s, c, o}

  dcs_decode u_dec (.insn(insn), .f(f));

  assign op_a = fp_modify(src_a, f.a_abs, f.a_neg);
  assign op_b = fp_modify(src_b, f.b_abs, f.b_neg);

  dcs_fp64_cmp #(.EXP_W(11), .FRAC_W(52)) u_cmp (
    .a(op_a), .b(op_b), .cnd(f.cnd), .pass(cmp_pass)
  );

  dcs_merge u_merge (
    .cmp_pass(cmp_pass), .preds(pred_file), .psel(f.psel), .pinv(f.pinv),
    .bop(f.bop), .float_one(f.float_one), .result(result)
  );

  assign in_ready = !out_valid || out_ready;
  assign in_fire  = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_data  <= '0;
      res_dest  <= '0;
    end else if (in_fire) begin
      out_valid <= 1'b1;
      res_data  <= result;
      res_dest  <= f.dest;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  logic res_is_zero;
  assign res_is_zero = (result == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= 4'b0000;
    end else if (in_fire && f.upd_flags) begin
      flags_q <= {res_is_zero, (f.float_one ? 1'b0 : !res_is_zero), 2'b00};
    end
  end

  assign {flag_zero, flag_sign, flag_carry, flag_ovf} = flags_q;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(res_data) && $stable(res_dest))); // R11
  AST_RES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (res_data == 32'h0 || res_data == 32'hFFFF_FFFF || res_data == 32'h3F80_0000)); // R8
  AST_DEST_FWD: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |=> (res_dest == $past(insn[7:0]))); // R1
  AST_FLAGS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && !insn[47]) |=> $stable(flags_q)); // R10
  AST_CO_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && insn[47]) |=> (!flag_carry && !flag_ovf)); // R9
  AST_SZ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_fire && insn[47]) |=> !(flag_zero && flag_sign)); // R9
endmodule

// File: tb/dcs_unit_tb_top.sv
module dcs_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] insn = '0;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic [7:0]  pred_file = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] res_data;
  logic [7:0]  res_dest;
  logic        flag_zero, flag_sign, flag_carry, flag_ovf;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  dcs_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .insn(insn), .src_a(src_a), .src_b(src_b), .pred_file(pred_file),
    .out_valid(out_valid), .out_ready(out_ready), .res_data(res_data),
    .res_dest(res_dest), .flag_zero(flag_zero), .flag_sign(flag_sign),
    .flag_carry(flag_carry), .flag_ovf(flag_ovf)
  );

  // Behavioural reference model.
  bit        m_valid;
  bit [31:0] m_res;
  bit [7:0]  m_dest;
  bit        m_z, m_s, m_c, m_o;

  function automatic bit is_nan(input logic [63:0] x);
    return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
  endfunction

  function automatic bit [31:0] ref_result(input logic [63:0] w, input logic [63:0] a,
                                           input logic [63:0] b, input logic [7:0] pf);
    logic [63:0] xa, xb;
    real ra, rb;
    bit u, c, p, h;
    xa = a; xb = b;
    if (w[54]) xa[63] = 0;           // R2 abs before negate
    if (w[43]) xa[63] = ~xa[63];
    if (w[44]) xb[63] = 0;
    if (w[53]) xb[63] = ~xb[63];
    u  = is_nan(xa) || is_nan(xb);   // R4
    ra = $bitstoreal(xa);
    rb = $bitstoreal(xb);             // R5: real compare treats -0 == +0
    case (w[51:48])                   // R3
      0:  c = 0;
      1:  c = !u && ra <  rb;
      2:  c = !u && ra == rb;
      3:  c = !u && ra <= rb;
      4:  c = !u && ra >  rb;
      5:  c = !u && ra != rb;
      6:  c = !u && ra >= rb;
      7:  c = !u;
      8:  c = u;
      9:  c = u || ra <  rb;
      10: c = u || ra == rb;
      11: c = u || ra <= rb;
      12: c = u || ra >  rb;
      13: c = u || ra != rb;
      14: c = u || ra >= rb;
      default: c = 1;
    endcase
    p = pf[w[41:39]] ^ w[42];         // R6
    case (w[46:45])                   // R7
      2'd1:    h = c | p;
      2'd2:    h = c ^ p;
      default: h = c & p;
    endcase
    if (!h) return 32'h0;             // R8
    return w[52] ? 32'h3F80_0000 : 32'hFFFF_FFFF;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; m_res = 0; m_dest = 0;
      m_z = 0; m_s = 0; m_c = 0; m_o = 0;
    end else if (in_valid && (!m_valid || out_ready)) begin
      m_valid = 1;
      m_res   = ref_result(insn, src_a, src_b, pred_file);
      m_dest  = insn[7:0];            // R1
      if (insn[47]) begin             // R9
        m_z = (m_res == 0);
        m_s = insn[52] ? 1'b0 : !m_z;
        m_c = 0; m_o = 0;
      end                             // R10: otherwise flags held
    end else if (out_ready) begin
      m_valid = 0;
    end
  end

  task automatic check_outputs();
    vectors++;
    if (in_ready !== (!m_valid || out_ready)) begin
      miscompares++;
      $display("FAIL R11 in_ready act=%0b exp=%0b", in_ready, !m_valid || out_ready);
    end
    if (out_valid !== m_valid) begin
      miscompares++;
      $display("FAIL R11 out_valid act=%0b exp=%0b", out_valid, m_valid);
    end
    if (m_valid && res_data !== m_res) begin
      miscompares++;
      $display("FAIL R3/R8 res_data act=%h exp=%h", res_data, m_res);
    end
    if (m_valid && res_dest !== m_dest) begin
      miscompares++;
      $display("FAIL R1 res_dest act=%h exp=%h", res_dest, m_dest);
    end
    if ({flag_zero, flag_sign, flag_carry, flag_ovf} !== {m_z, m_s, m_c, m_o}) begin
      miscompares++;
      $display("FAIL R9/R10 flags act=%b exp=%b",
               {flag_zero, flag_sign, flag_carry, flag_ovf}, {m_z, m_s, m_c, m_o});
    end
  endtask

  function automatic logic [63:0] pick_operand();
    case ($urandom_range(0, 11))
      0:  return 64'h0000_0000_0000_0000;  // +0 (R5)
      1:  return 64'h8000_0000_0000_0000;  // -0 (R5)
      2:  return 64'h3FF0_0000_0000_0000;  // 1.0
      3:  return 64'hBFF0_0000_0000_0000;  // -1.0
      4:  return 64'h4000_0000_0000_0000;  // 2.0
      5:  return 64'h7FF8_0000_0000_0001;  // NaN (R4)
      6:  return 64'h7FF0_0000_0000_0000;  // +inf
      7:  return 64'hFFF0_0000_0000_0000;  // -inf
      8:  return 64'h0000_0000_0000_0001;  // denormal
      9:  return 64'hFFF0_0000_0000_0010;  // negative NaN (R4)
      default: return {$urandom, $urandom};
    endcase
  endfunction

  task automatic drive_random(input int stall_pct);
    in_valid  = ($urandom_range(0, 99) < 85);
    out_ready = ($urandom_range(0, 99) >= stall_pct);
    insn      = {$urandom, $urandom};
    src_a     = pick_operand();
    src_b     = ($urandom_range(0, 3) == 0) ? src_a : pick_operand();
    pred_file = 8'($urandom);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs();                   // R11 reset state
    // Directed: -0 vs +0, EQ, AND with pred 0 set, mask result, flags on (R5 R9).
    in_valid = 1; out_ready = 1; pred_file = 8'h01;
    insn = 64'h0;
    insn[51:48] = 4'd2; insn[47] = 1; insn[7:0] = 8'h5A;
    src_a = 64'h8000_0000_0000_0000; src_b = 64'h0;
    @(negedge clk); check_outputs();
    // Directed: NaN with LT fails, float-one, flags on; then flags off (R4 R10).
    insn[51:48] = 4'd1; insn[52] = 1; src_a = 64'h7FF8_0000_0000_0000;
    @(negedge clk); check_outputs();
    insn[47] = 0; insn[51:48] = 4'd9;
    @(negedge clk); check_outputs();
    // Random phases: free flow, moderate stall, heavy stall (R2 R3 R6 R7 R11).
    for (int ph = 0; ph < 3; ph++) begin
      for (int i = 0; i < 1500; i++) begin
        drive_random(ph * 35);
        @(negedge clk); check_outputs();
      end
    end
    in_valid = 0; out_ready = 1;
    repeat (3) begin @(negedge clk); check_outputs(); end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog act=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule